// File: doc/BRIEF.md
# Console UART Register Front-End

This block is a byte-wide register file that a simple serial-port driver can detect and use like a basic 8250-class port, with no real line behind it. A bus master reads and writes eight byte offsets. Received characters arrive on a valid/data input stream and are held in one slot. Transmitted characters leave on a one-cycle output strobe, after a filter that drops form feed and bytes with the top bit set.

The block tracks two pending interrupt sources, transmit-ready and receive-held, and ORs them onto a single interrupt line. Every transmitted byte clears transmit-ready and starts a delay timer. When the timer expires, transmit-ready is raised again if the enable bit is still set. A command write can arm a one-shot indirect status read, which reports the interrupt source in place of the line status.

Bus reads are combinational within the access cycle. Their side effects (taking a character, leaving indirect mode) take place on the closing clock edge.

Top module: `cons_uart_front`

## Requirements
- R1: After reset, irq, txValid and ackErr are 0. A status read (offset 5) returns 0x64, an enable read (offset 1) returns 0x00, and an interrupt-identity read (offset 2) returns 0x01.
- R2: A read of offset 0 returns the held byte and clears the held flag. A data read does not take a byte from the receive stream.
- R3: A normal status read returns 0x64, with bit 0 also set when a byte is held or rxValid is high. When no byte is held, a status read with rxValid high asserts rxTake and latches rxData, which makes receive pending.
- R4: Writing 0x03 to offset 3 arms an indirect read. The next status read returns 0x10 if transmit is pending, otherwise 0x20 if receive is pending (held, or taken by that read), otherwise 0x00. Later status reads are normal.
- R5: Writing 0x28 to offset 3 clears pending transmit. If transmit was not pending, ackErr is high for exactly the one cycle after the write.
- R6: An enable read returns 0x0F only when the stored enable byte is exactly 0x0F, and 0x00 otherwise.
- R7: An enable write stores the byte. With bit 1 set, transmit becomes pending on that edge. With bit 1 clear, transmit pending clears and any running delay is cancelled.
- R8: A data write clears transmit pending and (re)starts a TX_DELAY-cycle timer. On the TX_DELAY-th clock edge after the write, transmit becomes pending only if enable bit 1 is set.
- R9: An interrupt-identity read returns bit 0 = 0 when anything is pending and 1 otherwise; bits 7..1 read 0. irq is high when transmit or receive is pending.
- R10: A written byte appears on txData with a one-cycle txValid in the cycle after the write, unless it is 0x0C or 0x80..0xFF. Those bytes produce no strobe.
- R11: Offsets 4, 6 and 7 read 0x00, and writes to them change nothing. Command bytes 0x00, 0x01 and 0x12 change nothing except overwriting an armed indirect mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Byte register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the access cycle |
| rxValid | input | 1 | Receive stream byte available |
| rxData | input | 8 | Receive stream byte |
| rxTake | output | 1 | Receive byte consumed this cycle |
| txValid | output | 1 | Transmit byte strobe |
| txData | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request |
| ackErr | output | 1 | Acknowledge with nothing pending |

## Verification
The assertions assume at most one register access per cycle, with busWr and busAddr stable while busSel is high. They also assume the receive source holds rxValid and rxData until it sees rxTake. The bench makes each access a single cycle through one task, and it raises rxValid only just before a status or data read and drops it right after that read. Timer checks keep the receive slot empty, so irq reflects transmit pending alone.

// File: rtl/cons_uart_pkg.sv
package cons_uart_pkg;
  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_IER  = 3'd1;
  localparam logic [2:0] OFF_IIR  = 3'd2;
  localparam logic [2:0] OFF_CMD  = 3'd3;
  localparam logic [2:0] OFF_STAT = 3'd5;

  localparam logic [7:0] CMD_INDIRECT = 8'h03;
  localparam logic [7:0] CMD_TXACK    = 8'h28;
  localparam logic [7:0] STAT_BASE    = 8'h64;
  localparam logic [7:0] IER_PROBE    = 8'h0F;
  localparam logic [7:0] SRC_TX       = 8'h10;
  localparam logic [7:0] SRC_RX       = 8'h20;
  localparam logic [7:0] FORM_FEED    = 8'h0C;
  localparam int         IER_TX_BIT   = 1;

  typedef struct packed {
    logic rdData;
    logic rdStatus;
    logic rdIer;
    logic rdIir;
    logic wrData;
    logic wrIer;
    logic indirect;
    logic txPend;
  } ctl_t;
endpackage

// File: rtl/cons_uart_ctl.sv
module cons_uart_ctl
  import cons_uart_pkg::*;
#(
  parameter int TX_DELAY = 300
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWdata,
  input  logic       ierTxEn,
  output ctl_t       ctl,
  output logic       ackErr
);
  localparam int CNT_W = $clog2(TX_DELAY + 1);

  logic [7:0]       cmdReg;
  logic             txPend;
  logic             timerOn;
  logic [CNT_W-1:0] timerCnt;
  logic             rdAcc, wrAcc, wrCmd, timerFire;

  assign rdAcc = busSel && !busWr;
  assign wrAcc = busSel && busWr;
  assign wrCmd = wrAcc && (busAddr == OFF_CMD);
  assign timerFire = timerOn && (timerCnt == CNT_W'(1));

  always_comb begin
    ctl.rdData   = rdAcc && (busAddr == OFF_DATA);
    ctl.rdStatus = rdAcc && (busAddr == OFF_STAT);
    ctl.rdIer    = rdAcc && (busAddr == OFF_IER);
    ctl.rdIir    = rdAcc && (busAddr == OFF_IIR);
    ctl.wrData   = wrAcc && (busAddr == OFF_DATA);
    ctl.wrIer    = wrAcc && (busAddr == OFF_IER);
    ctl.indirect = (cmdReg == CMD_INDIRECT);
    ctl.txPend   = txPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg   <= '0;
      txPend   <= 1'b0;
      timerOn  <= 1'b0;
      timerCnt <= '0;
      ackErr   <= 1'b0;
    end else begin
      ackErr <= 1'b0;
      if (timerOn) begin
        timerCnt <= timerCnt - CNT_W'(1);
        if (timerFire) begin
          timerOn <= 1'b0;
          if (ierTxEn) txPend <= 1'b1;
        end
      end
      if (ctl.wrData) begin
        txPend   <= 1'b0;
        timerOn  <= 1'b1;
        timerCnt <= CNT_W'(TX_DELAY);
      end
      if (ctl.wrIer) begin
        if (busWdata[IER_TX_BIT]) begin
          txPend <= 1'b1;
        end else begin
          txPend  <= 1'b0;
          timerOn <= 1'b0;
        end
      end
      if (wrCmd) begin
        cmdReg <= busWdata;
        if (busWdata == CMD_TXACK) begin
          if (txPend) txPend <= 1'b0;
          else        ackErr <= 1'b1;
        end
      end
      if (ctl.rdStatus && ctl.indirect) cmdReg <= '0;
    end
  end

  // R7: enable write with the transmit bit raises pending
  p_ier_raise_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == OFF_IER && busWdata[IER_TX_BIT]) |=> txPend);
  // R7: enable write without it clears pending and cancels the delay
  p_ier_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == OFF_IER && !busWdata[IER_TX_BIT]) |=> (!txPend && !timerOn));
  // R8: data write clears pending and starts the delay
  p_data_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == OFF_DATA) |=> (!txPend && timerOn));
  // R8: a running counter stays inside its window
  p_timer_window_r8: assert property (@(posedge clk) disable iff (!rstN)
    timerOn |-> (timerCnt != '0 && timerCnt <= CNT_W'(TX_DELAY)));
  // R5: acknowledge leaves nothing pending
  p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == OFF_CMD && busWdata == CMD_TXACK) |=> !txPend);
  // R5: the error pulse only follows an acknowledge with nothing pending
  p_ack_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    ackErr |-> ($past(!txPend) && !$past(ackErr)));
  // R4: indirect mode is consumed by one status read
  p_indirect_once_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == OFF_STAT && cmdReg == CMD_INDIRECT) |=> !ctl.indirect);
endmodule

// File: rtl/cons_uart_dp.sv
module cons_uart_dp
  import cons_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctl_t       ctl,
  input  logic [7:0] busWdata,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  output logic [7:0] busRdata,
  output logic       rxTake,
  output logic       txValid,
  output logic [7:0] txData,
  output logic       irq,
  output logic       ierTxEn
);
  logic       rxHeld;
  logic [7:0] rxSlot;
  logic [7:0] ierReg;
  logic       rxPendNow, txPass;

  assign rxTake    = ctl.rdStatus && !rxHeld && rxValid;
  assign rxPendNow = rxHeld || rxTake;
  assign txPass    = !busWdata[7] && (busWdata != FORM_FEED);
  assign irq       = ctl.txPend || rxHeld;
  assign ierTxEn   = ierReg[IER_TX_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHeld  <= 1'b0;
      rxSlot  <= '0;
      ierReg  <= '0;
      txValid <= 1'b0;
      txData  <= '0;
    end else begin
      txValid <= 1'b0;
      if (rxTake) begin
        rxHeld <= 1'b1;
        rxSlot <= rxData;
      end
      if (ctl.rdData) rxHeld <= 1'b0;
      if (ctl.wrIer) ierReg <= busWdata;
      if (ctl.wrData && txPass) begin
        txValid <= 1'b1;
        txData  <= busWdata;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (ctl.rdData) begin
      busRdata = rxSlot;
    end else if (ctl.rdIer) begin
      busRdata = (ierReg == IER_PROBE) ? IER_PROBE : 8'h00;
    end else if (ctl.rdIir) begin
      busRdata = {7'b0, !(ctl.txPend || rxHeld)};
    end else if (ctl.rdStatus) begin
      if (ctl.indirect)
        busRdata = ctl.txPend ? SRC_TX : (rxPendNow ? SRC_RX : 8'h00);
      else
        busRdata = STAT_BASE | {7'b0, rxPendNow};
    end
  end

  // R10: filtered bytes never reach the transmit strobe
  p_tx_filter_r10: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (!txData[7] && txData != FORM_FEED));
  // R10: each strobe lasts one cycle per write
  p_tx_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(ctl.wrData));
  // R3: a taken byte is held afterwards
  p_take_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxTake |=> rxHeld);
  // R2: a data read empties the slot
  p_data_empty_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdData |=> !rxHeld);
endmodule

// File: rtl/cons_uart_front.sv
module cons_uart_front
  import cons_uart_pkg::*;
#(
  parameter int TX_DELAY = 300
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  output logic       rxTake,
  output logic       txValid,
  output logic [7:0] txData,
  output logic       irq,
  output logic       ackErr
);
  ctl_t ctl;
  logic ierTxEn;

  cons_uart_ctl #(.TX_DELAY(TX_DELAY)) i_ctl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .ierTxEn(ierTxEn),
    .ctl(ctl), .ackErr(ackErr)
  );

  cons_uart_dp i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busWdata(busWdata),
    .rxValid(rxValid), .rxData(rxData), .busRdata(busRdata),
    .rxTake(rxTake), .txValid(txValid), .txData(txData),
    .irq(irq), .ierTxEn(ierTxEn)
  );
endmodule

// File: tb/test_cons_uart_front.sv
module test_cons_uart_front;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxTake, txValid, irq, ackErr;
  logic [7:0] txData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] rdExpQ[$];
  string      rdTagQ[$];
  logic [7:0] txExpQ[$];

  always #4 clk = ~clk;

  cons_uart_front i_cons_uart_front (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rxValid(rxValid), .rxData(rxData), .rxTake(rxTake),
    .txValid(txValid), .txData(txData), .irq(irq), .ackErr(ackErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit passTx(input logic [7:0] b);
    return (b < 8'h80) && (b != 8'h0C);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    if (a == 3'd0 && passTx(d)) txExpQ.push_back(d);
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rdExpQ.push_back(exp); rdTagQ.push_back(tag);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (busSel && !busWr) begin
      if (rdExpQ.size() == 0) chk("read with no expectation", 32'(busRdata), 32'hFFFF);
      else begin
        logic [7:0] e;
        string t;
        e = rdExpQ.pop_front();
        t = rdTagQ.pop_front();
        chk(t, 32'(busRdata), 32'(e));
      end
    end
    if (txValid) begin
      if (txExpQ.size() == 0) chk("R10 unexpected tx byte", 32'(txData), 32'hFFFF);
      else begin
        logic [7:0] e;
        e = txExpQ.pop_front();
        chk("R10 tx byte", 32'(txData), 32'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 txValid", 32'(txValid), 0);
    chk("R1 ackErr", 32'(ackErr), 0);
    rd(3'd5, 8'h64, "R1 status");
    rd(3'd1, 8'h00, "R1 ier");
    rd(3'd2, 8'h01, "R1 iir");
    rd(3'd4, 8'h00, "R11 offset 4 read");

    // R10 filter, enable clear
    wr(3'd0, 8'h41);
    chk("R10 strobe after pass", 32'(txValid), 1);
    wr(3'd0, 8'h0C);
    chk("R10 form feed dropped", 32'(txValid), 0);
    wr(3'd0, 8'h0A);
    wr(3'd0, 8'h80);
    chk("R10 high byte dropped", 32'(txValid), 0);
    wr(3'd0, 8'hFF);
    wr(3'd0, 8'h7F);
    wr(3'd0, 8'h00);
    idle(310);
    chk("R8 expiry with enable clear", 32'(irq), 0);

    // R6 / R7
    wr(3'd1, 8'h0F);
    chk("R7 raise on enable", 32'(irq), 1);
    rd(3'd1, 8'h0F, "R6 probe echo");
    rd(3'd2, 8'h00, "R9 iir pending");
    wr(3'd1, 8'h07);
    rd(3'd1, 8'h00, "R6 other value");
    wr(3'd1, 8'h02);
    rd(3'd1, 8'h00, "R6 bit1 only");
    wr(3'd1, 8'h00);
    chk("R7 clear on disable", 32'(irq), 0);
    rd(3'd2, 8'h01, "R9 iir idle");

    // R8 delay
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h42);
    chk("R8 cleared by data write", 32'(irq), 0);
    idle(299);
    chk("R8 before expiry", 32'(irq), 0);
    idle(1);
    chk("R8 at expiry", 32'(irq), 1);
    wr(3'd0, 8'h43);
    idle(150);
    wr(3'd0, 8'h44);
    idle(299);
    chk("R8 restart before expiry", 32'(irq), 0);
    idle(1);
    chk("R8 restart at expiry", 32'(irq), 1);
    wr(3'd0, 8'h45);
    idle(10);
    wr(3'd1, 8'h00);
    idle(400);
    chk("R7 delay cancelled", 32'(irq), 0);

    // R5 acknowledge
    wr(3'd1, 8'h02);
    wr(3'd3, 8'h28);
    chk("R5 ack clears", 32'(irq), 0);
    chk("R5 no error on valid ack", 32'(ackErr), 0);
    wr(3'd3, 8'h28);
    chk("R5 error pulse", 32'(ackErr), 1);
    idle(1);
    chk("R5 error one cycle", 32'(ackErr), 0);

    // R11 benign commands, R4 indirect
    wr(3'd1, 8'h02);
    wr(3'd3, 8'h00);
    wr(3'd3, 8'h01);
    wr(3'd3, 8'h12);
    chk("R11 commands keep pending", 32'(irq), 1);
    rd(3'd5, 8'h64, "R11 status stays normal");
    wr(3'd3, 8'h03);
    wr(3'd3, 8'h12);
    rd(3'd5, 8'h64, "R11 overwrite disarms");
    wr(3'd3, 8'h03);
    rd(3'd5, 8'h10, "R4 tx source");
    rd(3'd5, 8'h64, "R4 back to normal");

    // R11 unlisted writes
    wr(3'd1, 8'h0F);
    wr(3'd4, 8'hFF);
    wr(3'd6, 8'h00);
    wr(3'd7, 8'h00);
    rd(3'd1, 8'h0F, "R11 ier untouched");
    rd(3'd6, 8'h00, "R11 offset 6 read");
    rd(3'd7, 8'h00, "R11 offset 7 read");
    chk("R11 pending untouched", 32'(irq), 1);
    wr(3'd3, 8'h28);
    wr(3'd1, 8'h00);

    // R3 / R2 receive path
    rxValid = 1'b1; rxData = 8'h5A;
    rd(3'd5, 8'h65, "R3 status takes byte");
    rxValid = 1'b0;
    chk("R3 irq on held byte", 32'(irq), 1);
    rd(3'd5, 8'h65, "R3 status held");
    rd(3'd2, 8'h00, "R9 iir rx pending");
    wr(3'd3, 8'h03);
    rd(3'd5, 8'h20, "R4 rx source");
    rd(3'd0, 8'h5A, "R2 data read");
    rd(3'd5, 8'h64, "R2 slot emptied");
    chk("R2 irq cleared", 32'(irq), 0);
    rxValid = 1'b1; rxData = 8'h33;
    rd(3'd0, 8'h5A, "R2 data read does not take");
    chk("R2 nothing latched", 32'(irq), 0);
    rd(3'd5, 8'h65, "R3 status takes second byte");
    rxValid = 1'b0;
    rd(3'd0, 8'h33, "R2 second byte");
    wr(3'd3, 8'h03);
    rd(3'd5, 8'h00, "R4 no source");
    rd(3'd5, 8'h64, "R4 normal after empty");

    idle(2);
    chk("R10 no missing tx bytes", 32'(txExpQ.size()), 0);
    chk("scoreboard reads drained", 32'(rdExpQ.size()), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule